// File: doc/BRIEF.md
# Prioritized Interrupt Context Switcher

This block steers a small processor between its task state and four nested executive states, classes I to IV, with class IV the most urgent. It looks at interrupt requests only when the processor signals that an instruction has just finished. When it accepts a request, it first shuts out every other request. It then parks the interrupted program counter and status word in a save slot that belongs to the accepted class. Next it fetches that class's handler address and initial status word from the class's vector slot and presents them to the processor.

A return request reverses one level of nesting. The block reloads the context that was parked when the current level was entered, so the state below resumes at its next sequential instruction. A depth-four nesting stack records which classes are active. The task state comes back only after every nested handler has returned.

Vector slots are written through a configuration port while reset is held. The processor supplies its current program counter. The status word is held inside the block and is presented on `st_o`.

Top module: `irq_seq`

## Requirements
- R1: A request is taken only on a cycle where `bnd_i` is high, the block is idle and `ret_i` is low. Requests present without a boundary strobe start nothing.
- R2: An accepted request makes `busy_o` high for exactly 6 cycles: lockout, save PC, save status, load PC, load status, release. `load_o` is high only in the last of these cycles. Boundary strobes and requests arriving while `busy_o` is high are ignored.
- R3: When several enabled requests are pending at a boundary, the highest bit of `irq_i` is taken. Bit k is class k+1, so bit 3 is class IV.
- R4: Entry stores the interrupted `cur_pc_i` and the current `st_o` in the save slot of the class being entered. The matching return places exactly those two values back on `pc_o` and `st_o`.
- R5: At the `load_o` pulse after an entry, `pc_o` equals the class's vector address. `st_o` equals the class's vector status word in every bit outside the enable field. `pc_o` and `st_o` never change on the clock edge that ends an idle cycle.
- R6: Status word bits [6:3] enable classes I to IV, with bit 3+k for class k+1. After entry into class k+1, the enable bits are the vector's enable bits ANDed with a mask that keeps only classes above k+1. No status word on `st_o` enables a class at or below its own state.
- R7: Status bits [2:0] hold the state code: 0 for the task state and k+1 for class k+1. `state_o` shows this code, and `bank_o` is one-hot with bit `state_o` set.
- R8: A return from a nested level takes 2 busy cycles, with `load_o` in the second. It resumes the next lower state. The task state (code 0) returns only after every nested level has returned.
- R9: A return request in the task state pulses `ret_err_o` for one cycle in the next cycle. It leaves `pc_o`, `st_o` and `busy_o` unchanged.
- R10: After reset the block is in the task state, with `pc_o` = 0, all four class enables set, `st_o` = 0x78 for the default widths, and `busy_o` and `load_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Vector slot write enable |
| cfg_cls_i | input | IW | Class index of the vector slot to write |
| cfg_pc_i | input | PC_W | Handler start address to store |
| cfg_st_i | input | SW_W | Handler initial status word to store |
| irq_i | input | NCLS | Interrupt requests, bit k = class k+1 |
| bnd_i | input | 1 | Instruction boundary strobe |
| cur_pc_i | input | PC_W | Address of the next instruction of the running state |
| ret_i | input | 1 | Handler return request |
| pc_o | output | PC_W | Program counter to load |
| st_o | output | SW_W | Active status word |
| state_o | output | FW | Active state code |
| bank_o | output | NCLS+1 | One-hot register bank select |
| load_o | output | 1 | New PC/status are ready to load |
| busy_o | output | 1 | Context switch in progress |
| ret_err_o | output | 1 | Return request made in the task state |

## Verification
On every cycle, the assertions check four things. Nothing starts without a boundary or return, and the load pulse always closes a busy window. The outputs hold still across idle cycles. The active status word never enables its own class or a lower one, and the bank select stays one-hot. Only the bench scenarios can show the rest: that the highest of all fifteen request patterns wins, that parked contexts come back in strict reverse order across four levels, and that strobes during a sequence are dropped. Each of these needs the programmed vectors and a count of cycles.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOCK,
    SQ_SAVE_PC,
    SQ_SAVE_ST,
    SQ_LOAD_PC,
    SQ_LOAD_ST,
    SQ_RET,
    SQ_RELEASE
  } seq_e;
endpackage

// File: rtl/seq_prio.sv
module seq_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // the highest set bit wins, since later iterations overwrite earlier ones
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int j = 0; j < N; j++) begin
      if (req_i[j]) begin
        hit_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/seq_slots.sv
module seq_slots #(
  parameter int N    = 4,
  parameter int PC_W = 16,
  parameter int SW_W = 8,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            cfg_we_i,
  input  logic [IW-1:0]   cfg_idx_i,
  input  logic [PC_W-1:0] cfg_pc_i,
  input  logic [SW_W-1:0] cfg_st_i,
  input  logic [IW-1:0]   idx_i,
  input  logic            sav_pc_we_i,
  input  logic            sav_st_we_i,
  input  logic [PC_W-1:0] sav_pc_i,
  input  logic [SW_W-1:0] sav_st_i,
  output logic [PC_W-1:0] vec_pc_o,
  output logic [SW_W-1:0] vec_st_o,
  output logic [PC_W-1:0] sav_pc_o,
  output logic [SW_W-1:0] sav_st_o
);
  logic [PC_W-1:0] vpc [N];
  logic [SW_W-1:0] vst [N];
  logic [PC_W-1:0] spc [N];
  logic [SW_W-1:0] sst [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (cfg_we_i && cfg_idx_i == IW'(g)) begin
        vpc[g] <= cfg_pc_i;
        vst[g] <= cfg_st_i;
      end
      if (sav_pc_we_i && idx_i == IW'(g)) spc[g] <= sav_pc_i;
      if (sav_st_we_i && idx_i == IW'(g)) sst[g] <= sav_st_i;
    end
  end

  always_comb begin
    vec_pc_o = '0;
    vec_st_o = '0;
    sav_pc_o = '0;
    sav_st_o = '0;
    for (int j = 0; j < N; j++) begin
      if (idx_i == IW'(j)) begin
        vec_pc_o = vpc[j];
        vec_st_o = vst[j];
        sav_pc_o = spc[j];
        sav_st_o = sst[j];
      end
    end
  end
endmodule

// File: rtl/seq_nest.sv
module seq_nest #(
  parameter int N  = 4,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int SPW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [IW-1:0] push_idx_i,
  output logic          empty_o,
  output logic [IW-1:0] top_o
);
  logic [SPW-1:0] sp_q;
  logic [IW-1:0]  stk [N];

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else if (push_i && sp_q != SPW'(N)) sp_q <= sp_q + 1'b1;
    else if (pop_i && sp_q != '0) sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) stk[g] <= '0;
      else if (push_i && sp_q == SPW'(g)) stk[g] <= push_idx_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int j = 0; j < N; j++)
      if (sp_q == SPW'(j + 1)) top_o = stk[j];
  end

  assign empty_o = (sp_q == '0);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int NCLS = 4,
  parameter int PC_W = 16,
  parameter int SW_W = 8,
  parameter logic [PC_W-1:0] RST_PC = '0,
  localparam int IW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int FW = $clog2(NCLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we_i,
  input  logic [IW-1:0]   cfg_cls_i,
  input  logic [PC_W-1:0] cfg_pc_i,
  input  logic [SW_W-1:0] cfg_st_i,
  input  logic [NCLS-1:0] irq_i,
  input  logic            bnd_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic            ret_i,
  output logic [PC_W-1:0] pc_o,
  output logic [SW_W-1:0] st_o,
  output logic [FW-1:0]   state_o,
  output logic [NCLS:0]   bank_o,
  output logic            load_o,
  output logic            busy_o,
  output logic            ret_err_o
);
  localparam logic [SW_W-1:0] RST_ST = SW_W'(((1 << NCLS) - 1) << FW);

  seq_e            fsm_q;
  logic [IW-1:0]   cls_q;
  logic [PC_W-1:0] pc_cap_q, pc_q;
  logic [SW_W-1:0] st_q;
  logic            err_q;

  logic [NCLS-1:0] pend, hi_mask;
  logic            hit, empty;
  logic [IW-1:0]   pick, top;
  logic [PC_W-1:0] vec_pc, sav_pc;
  logic [SW_W-1:0] vec_st, sav_st, vec_st_m;

  // requests are gated by the active enable field; outside IDLE nothing is sampled
  assign pend = irq_i & st_q[FW +: NCLS];

  seq_prio #(.N(NCLS)) u_prio (
    .req_i(pend), .hit_o(hit), .idx_o(pick)
  );

  seq_slots #(.N(NCLS), .PC_W(PC_W), .SW_W(SW_W)) u_slots (
    .clk(clk),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_cls_i),
    .cfg_pc_i(cfg_pc_i), .cfg_st_i(cfg_st_i),
    .idx_i(cls_q),
    .sav_pc_we_i(fsm_q == SQ_SAVE_PC),
    .sav_st_we_i(fsm_q == SQ_SAVE_ST),
    .sav_pc_i(pc_cap_q), .sav_st_i(st_q),
    .vec_pc_o(vec_pc), .vec_st_o(vec_st),
    .sav_pc_o(sav_pc), .sav_st_o(sav_st)
  );

  seq_nest #(.N(NCLS)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .push_i(fsm_q == SQ_LOAD_ST),
    .pop_i(fsm_q == SQ_RET),
    .push_idx_i(cls_q),
    .empty_o(empty), .top_o(top)
  );

  // keep only classes strictly above the one being entered
  always_comb begin
    for (int j = 0; j < NCLS; j++) hi_mask[j] = (j > int'(cls_q));
    vec_st_m = vec_st;
    vec_st_m[FW +: NCLS] = vec_st[FW +: NCLS] & hi_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q    <= SQ_IDLE;
      cls_q    <= '0;
      pc_cap_q <= '0;
      pc_q     <= RST_PC;
      st_q     <= RST_ST;
      err_q    <= 1'b0;
    end else begin
      err_q <= (fsm_q == SQ_IDLE) && ret_i && empty;
      case (fsm_q)
        SQ_IDLE: begin
          if (ret_i && !empty) begin
            fsm_q <= SQ_RET;
            cls_q <= top;
          end else if (!ret_i && bnd_i && hit) begin
            fsm_q    <= SQ_LOCK;
            cls_q    <= pick;
            pc_cap_q <= cur_pc_i;
          end
        end
        SQ_LOCK:    fsm_q <= SQ_SAVE_PC;
        SQ_SAVE_PC: fsm_q <= SQ_SAVE_ST;
        SQ_SAVE_ST: fsm_q <= SQ_LOAD_PC;
        SQ_LOAD_PC: begin
          pc_q  <= vec_pc;
          fsm_q <= SQ_LOAD_ST;
        end
        SQ_LOAD_ST: begin
          st_q  <= vec_st_m;
          fsm_q <= SQ_RELEASE;
        end
        SQ_RET: begin
          pc_q  <= sav_pc;
          st_q  <= sav_st;
          fsm_q <= SQ_RELEASE;
        end
        SQ_RELEASE: fsm_q <= SQ_IDLE;
        default:    fsm_q <= SQ_IDLE;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign st_o      = st_q;
  assign state_o   = st_q[FW-1:0];
  assign load_o    = (fsm_q == SQ_RELEASE);
  assign busy_o    = (fsm_q != SQ_IDLE);
  assign ret_err_o = err_q;

  always_comb begin
    for (int j = 0; j <= NCLS; j++) bank_o[j] = (state_o == FW'(j));
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NCLS = 4,
  parameter int PC_W = 16,
  parameter int SW_W = 8,
  localparam int FW = $clog2(NCLS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bnd_i,
  input logic            ret_i,
  input logic [PC_W-1:0] pc_o,
  input logic [SW_W-1:0] st_o,
  input logic [FW-1:0]   state_o,
  input logic [NCLS:0]   bank_o,
  input logic            load_o,
  input logic            busy_o,
  input logic            ret_err_o
);
  function automatic logic [NCLS-1:0] low_mask(input logic [FW-1:0] s);
    for (int j = 0; j < NCLS; j++) low_mask[j] = (j < int'(s));
  endfunction

  a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !bnd_i && !ret_i) |=> !busy_o);

  a_r2_load_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> busy_o);

  a_r2_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (!busy_o && !load_o));

  a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(pc_o) && $stable(st_o)));

  a_r6_only_higher_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o[FW +: NCLS] & low_mask(state_o)) == '0);

  a_r7_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_o) == 1);

  a_r9_err_in_task: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err_o |-> (state_o == '0 && !busy_o));
endmodule

bind irq_seq irq_seq_chk #(.NCLS(NCLS), .PC_W(PC_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .ret_i(ret_i),
  .pc_o(pc_o), .st_o(st_o), .state_o(state_o), .bank_o(bank_o),
  .load_o(load_o), .busy_o(busy_o), .ret_err_o(ret_err_o)
);

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_cls = '0;
  logic [15:0] cfg_pc = '0;
  logic [7:0]  cfg_st = '0;
  logic [3:0]  irq = '0;
  logic        bnd = 1'b0;
  logic [15:0] cur_pc = '0;
  logic        ret = 1'b0;
  logic [15:0] pc_o;
  logic [7:0]  st_o;
  logic [2:0]  state_o;
  logic [4:0]  bank_o;
  logic        load_o, busy_o, ret_err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cfg_we), .cfg_cls_i(cfg_cls), .cfg_pc_i(cfg_pc), .cfg_st_i(cfg_st),
    .irq_i(irq), .bnd_i(bnd), .cur_pc_i(cur_pc), .ret_i(ret),
    .pc_o(pc_o), .st_o(st_o), .state_o(state_o), .bank_o(bank_o),
    .load_o(load_o), .busy_o(busy_o), .ret_err_o(ret_err_o)
  );

  function automatic logic [15:0] vpc(input int k);
    return 16'(16'h1000 * (k + 1) + 16'h0040);
  endfunction
  function automatic logic [7:0] vst(input int k);
    return 8'(8'hF8 | (k + 1));
  endfunction
  function automatic logic [7:0] exp_st(input int k);
    logic [3:0] en;
    en = 4'hF & ~4'((2 << k) - 1);
    return {1'b1, en, 3'(k + 1)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // enter class k via request pattern; optional strobe for class IV mid-sequence
  task automatic do_enter(input logic [3:0] req, input logic [15:0] pc, input int k,
                          input bit mid);
    int n;
    @(negedge clk); irq = req; bnd = 1'b1; cur_pc = pc;
    @(negedge clk); bnd = 1'b0; irq = '0;
    chk(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
    n = 0;
    while (!load_o && n < 20) begin
      n++;
      if (mid && n == 1) begin bnd = 1'b1; irq = 4'b1000; end
      if (mid && n == 2) begin bnd = 1'b0; irq = '0; end
      @(negedge clk);
    end
    chk(n == 5, "R2 six busy cycles", n + 1, 6);
    chk(state_o == 3'(k + 1), "R3 taken class", int'(state_o), k + 1);
    chk(pc_o == vpc(k), "R5 vector pc", int'(pc_o), int'(vpc(k)));
    chk(bank_o == 5'(1 << (k + 1)), "R7 bank one-hot", int'(bank_o), 1 << (k + 1));
    @(negedge clk);
    chk(busy_o == 1'b0 && load_o == 1'b0, "R2 release", int'({busy_o, load_o}), 0);
  endtask

  task automatic do_ret(input logic [15:0] epc, input logic [7:0] est, input string tag);
    int n;
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    n = 0;
    while (!load_o && n < 20) begin n++; @(negedge clk); end
    chk(n == 1, "R8 two-cycle return", n + 1, 2);
    chk(pc_o == epc, {tag, " pc"}, int'(pc_o), int'(epc));
    chk(st_o == est, {tag, " status"}, int'(st_o), int'(est));
    chk(state_o == est[2:0], {tag, " state"}, int'(state_o), int'(est[2:0]));
    @(negedge clk);
  endtask

  task automatic do_bad_ret();
    logic [15:0] p;
    logic [7:0]  s;
    p = pc_o; s = st_o;
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    chk(ret_err_o == 1'b1, "R9 error pulse", int'(ret_err_o), 1);
    chk(busy_o == 1'b0 && pc_o == p && st_o == s, "R9 no effect",
        int'({busy_o, st_o}), int'({1'b0, s}));
    @(negedge clk);
    chk(ret_err_o == 1'b0, "R9 one-cycle pulse", int'(ret_err_o), 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_cls = 2'(k); cfg_pc = vpc(k); cfg_st = vst(k);
    end
    @(negedge clk); cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(pc_o == 16'h0 && st_o == 8'h78 && state_o == 3'd0, "R10 reset outputs",
        int'({pc_o, st_o}), int'(16'h0078));
    chk(!busy_o && !load_o && !ret_err_o, "R10 reset strobes",
        int'({busy_o, load_o, ret_err_o}), 0);
    chk(bank_o == 5'b00001, "R7 task bank", int'(bank_o), 1);

    // R1 requests without a boundary, and a boundary without requests
    irq = 4'hF;
    repeat (3) @(negedge clk);
    chk(!busy_o && state_o == 3'd0, "R1 no boundary ignored", int'(busy_o), 0);
    irq = '0; bnd = 1'b1;
    repeat (2) @(negedge clk);
    bnd = 1'b0;
    chk(!busy_o && state_o == 3'd0, "R1 empty boundary ignored", int'(busy_o), 0);

    // R3 every request pattern from the task state; R4 context returns
    for (int p = 1; p < 16; p++) begin
      int hb;
      hb = 0;
      for (int b = 0; b < 4; b++) if (p[b]) hb = b;
      do_enter(4'(p), 16'(16'h0200 + p), hb, 1'b0);
      chk(st_o == exp_st(hb), "R6 masked enables", int'(st_o), int'(exp_st(hb)));
      do_ret(16'(16'h0200 + p), 8'h78, "R4 restore");
    end

    // R2 strobe for class IV during an entry into class I is dropped
    do_enter(4'b0001, 16'h0333, 0, 1'b1);
    chk(state_o == 3'd1, "R2 mid strobe ignored", int'(state_o), 1);
    do_ret(16'h0333, 8'h78, "R4 restore after mid");

    // R8 full nesting, lower request ignored at the top, reverse unwinding
    do_enter(4'b0001, 16'h0A00, 0, 1'b0);
    do_enter(4'b0011, 16'h0A01, 1, 1'b0);
    do_enter(4'b0111, 16'h0A02, 2, 1'b0);
    do_enter(4'b1111, 16'h0A03, 3, 1'b0);
    chk(st_o[6:3] == 4'h0, "R6 class IV enables none", int'(st_o[6:3]), 0);
    @(negedge clk); irq = 4'hF; bnd = 1'b1;
    @(negedge clk); irq = '0; bnd = 1'b0;
    chk(!busy_o && state_o == 3'd4, "R6 locked classes ignored", int'(state_o), 4);
    do_ret(16'h0A03, exp_st(2), "R8 back to III");
    do_ret(16'h0A02, exp_st(1), "R8 back to II");
    do_ret(16'h0A01, exp_st(0), "R8 back to I");
    do_ret(16'h0A00, 8'h78, "R8 back to task");

    // R9 return with nothing nested
    do_bad_ret();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule